// File: doc/BRIEF.md
# E1 Line Performance Counter Bank

This block sits behind an E1 receive framer and keeps three performance tallies for the line: multiframe CRC check failures, far-end block errors reported through the E-bits, and frame alignment word errors. The framer hands it single-cycle event strobes together with its current synchronization status. A one-second tick from the system timebase closes each measurement interval: every running tally is copied into a held copy and the running tally restarts from zero.

Software or a monitoring agent reads the held values through a byte-wide, combinational read port at four consecutive addresses. The two 10-bit tallies take the low two bits of the upper byte at their address pair, and the 12-bit frame alignment tally is split in halves into the spare upper six bits of those two upper bytes. Event inputs carry no back-pressure: each strobe is a one-cycle valid pulse that the block always accepts, so there is no ready signal and a producer never waits.

CRC and E-bit counting pauses while alignment at either the basic-frame level or the CRC multiframe level is lost; loss of signalling multiframe alignment leaves counting running. The alignment word tally saturates rather than wrapping.

Top module: `e1_perf_counter_bank`

## Requirements
- R1: A cycle with `crc_chk_valid`=1 and `crc_chk_fail`=1 adds one to the CRC tally; `crc_chk_fail`=0 adds nothing. After a tick, tally bits 9:8 read at address 0x02 bits 1:0 and bits 7:0 read at address 0x03.
- R2: A cycle with `ebit_valid`=1, `ebit_value`=0 and `ebit_frame` (4-bit binary frame number 0..15) equal to 13 or 15 adds one to the E-bit tally. After a tick, tally bits 9:8 read at address 0x04 bits 1:0 and bits 7:0 read at address 0x05.
- R3: An E-bit equal to 1, or an E-bit reported in any frame other than 13 and 15, leaves the E-bit tally unchanged.
- R4: While `lost_fas_sync` or `lost_crc_sync` is 1, neither the CRC tally nor the E-bit tally changes.
- R5: `lost_cas_sync` has no effect on any tally.
- R6: Each cycle with `fas_word_err`=1 adds one to the 12-bit alignment tally, regardless of sync flags. After a tick, its bits 11:6 read at address 0x02 bits 7:2 and its bits 5:0 read at address 0x04 bits 7:2.
- R7: The alignment tally stops at 4095 and does not wrap.
- R8: On `sec_tick`=1 every running tally is copied to its held value and restarts; an event in the tick cycle is the first count of the new interval.
- R9: Reads return only held values, which change only on a tick; reads have no side effect; addresses other than 0x02..0x05 return 0x00.
- R10: Synchronous active-high `rst` clears all running and held tallies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crc_chk_valid | input | 1 | One-cycle strobe: a multiframe CRC check result is present |
| crc_chk_fail | input | 1 | Result of that check, 1 = mismatch |
| ebit_valid | input | 1 | One-cycle strobe: a received E-bit is present |
| ebit_value | input | 1 | Received E-bit, 0 = far-end block error |
| ebit_frame | input | 4 | Frame number within the multiframe the E-bit came from |
| fas_word_err | input | 1 | One-cycle strobe: alignment word received in error |
| lost_fas_sync | input | 1 | Basic frame alignment lost |
| lost_crc_sync | input | 1 | CRC multiframe alignment lost |
| lost_cas_sync | input | 1 | Signalling multiframe alignment lost |
| sec_tick | input | 1 | One-second interval strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |

## Verification
The bench builds the block with its default widths of 10, 10 and 12 bits and frame numbers 13 and 15, the only values the register packing supports. With these widths the 12-bit alignment tally reaches its 4095 ceiling within a few thousand strobes, so saturation is driven directly, and interval totals above 255 put nonzero bits into the two-bit high fields so the split between bytes is observed. The tick-coincident event and mid-interval reads are covered by directed cases.

// File: rtl/e1pc_pkg.sv
package e1pc_pkg;
  localparam int FRAME_W = 4;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;

  localparam logic [ADDR_W-1:0] A_CRC_HI = 8'h02;
  localparam logic [ADDR_W-1:0] A_CRC_LO = 8'h03;
  localparam logic [ADDR_W-1:0] A_EB_HI  = 8'h04;
  localparam logic [ADDR_W-1:0] A_EB_LO  = 8'h05;

  typedef struct packed {
    logic crc;
    logic ebit;
    logic fas;
  } cnt_evt_t;
endpackage

// File: rtl/e1pc_event_qual.sv
module e1pc_event_qual
  import e1pc_pkg::*;
#(
  parameter int FRAME_BITS = FRAME_W,
  parameter int EB_FRAME_A = 13,
  parameter int EB_FRAME_B = 15
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  crc_vld,
  input  logic                  crc_fail,
  input  logic                  eb_vld,
  input  logic                  eb_bit,
  input  logic [FRAME_BITS-1:0] eb_frame,
  input  logic                  fas_err,
  input  logic                  fas_lost,
  input  logic                  crc_lost,
  input  logic                  cas_lost,
  output cnt_evt_t              evt
);
  localparam logic [FRAME_BITS-1:0] FR_A = FRAME_BITS'(EB_FRAME_A);
  localparam logic [FRAME_BITS-1:0] FR_B = FRAME_BITS'(EB_FRAME_B);

  logic count_ok;
  logic eb_slot;

  // Only framing- and CRC-level loss pause counting; signalling loss is ignored.
  assign count_ok = !(fas_lost || crc_lost);
  assign eb_slot  = (eb_frame == FR_A) || (eb_frame == FR_B);

  always_comb begin
    evt.crc  = count_ok && crc_vld && crc_fail;
    evt.ebit = count_ok && eb_vld && eb_slot && !eb_bit;
    evt.fas  = fas_err;
  end

  AST_GATED_BY_SYNC: assert property (@(posedge clk) disable iff (rst)
    (fas_lost || crc_lost) |-> (!evt.crc && !evt.ebit)); // R4
  AST_EBIT_SLOT_ONLY: assert property (@(posedge clk) disable iff (rst)
    evt.ebit |-> ((eb_frame == FR_A) || (eb_frame == FR_B)) && !eb_bit); // R3
  AST_CAS_NOT_GATING: assert property (@(posedge clk) disable iff (rst)
    (cas_lost && !fas_lost && !crc_lost && crc_vld && crc_fail) |-> evt.crc); // R5
endmodule

// File: rtl/e1pc_interval_cnt.sv
module e1pc_interval_cnt #(
  parameter int W        = 10,
  parameter bit SATURATE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         inc,
  output logic [W-1:0] held
);
  localparam logic [W-1:0] MAX_V = {W{1'b1}};
  localparam logic [W-1:0] ONE   = W'(1);

  logic [W-1:0] run;
  logic [W-1:0] run_step;

  generate
    if (SATURATE) begin : g_sat
      always_comb run_step = (run == MAX_V) ? run : run + ONE;
    end else begin : g_wrap
      always_comb run_step = run + ONE;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= '0;
      held <= '0;
    end else if (tick) begin
      held <= run;
      run  <= inc ? ONE : '0;
    end else if (inc) begin
      run  <= run_step;
    end
  end

  AST_TICK_LATCH: assert property (@(posedge clk) disable iff (rst)
    tick |=> (held == $past(run))); // R8
  AST_TICK_RESTART: assert property (@(posedge clk) disable iff (rst)
    tick |=> (run == W'($past(inc)))); // R8
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(held)); // R9

  generate
    if (SATURATE) begin : g_sat_chk
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (run == MAX_V && !tick) |=> (run == MAX_V)); // R7
    end else begin : g_step_chk
      AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!tick && inc) |=> (run == $past(run) + ONE)); // R1
    end
  endgenerate
endmodule

// File: rtl/e1pc_reg_map.sv
module e1pc_reg_map
  import e1pc_pkg::*;
#(
  parameter int CW = 10,
  parameter int FW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CW-1:0]     crc_cnt,
  input  logic [CW-1:0]     eb_cnt,
  input  logic [FW-1:0]     fas_cnt,
  output logic [DATA_W-1:0] rdata
);
  localparam int HI_W   = CW - DATA_W;
  localparam int HALF_F = FW / 2;

  logic in_range;

  always_comb begin
    unique case (addr)
      A_CRC_HI: rdata = {fas_cnt[FW-1:HALF_F], crc_cnt[CW-1:DATA_W]};
      A_CRC_LO: rdata = crc_cnt[DATA_W-1:0];
      A_EB_HI:  rdata = {fas_cnt[HALF_F-1:0], eb_cnt[CW-1:DATA_W]};
      A_EB_LO:  rdata = eb_cnt[DATA_W-1:0];
      default:  rdata = '0;
    endcase
  end

  assign in_range = (addr >= A_CRC_HI) && (addr <= A_EB_LO);

  initial begin
    assert (HI_W + HALF_F == DATA_W); // R6
  end

  AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !in_range |-> (rdata == '0)); // R9
endmodule

// File: rtl/e1_perf_counter_bank.sv
module e1_perf_counter_bank
  import e1pc_pkg::*;
#(
  parameter int CRC_W      = 10,
  parameter int EB_W       = 10,
  parameter int FAS_W      = 12,
  parameter int EB_FRAME_A = 13,
  parameter int EB_FRAME_B = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               crc_chk_valid,
  input  logic               crc_chk_fail,
  input  logic               ebit_valid,
  input  logic               ebit_value,
  input  logic [FRAME_W-1:0] ebit_frame,
  input  logic               fas_word_err,
  input  logic               lost_fas_sync,
  input  logic               lost_crc_sync,
  input  logic               lost_cas_sync,
  input  logic               sec_tick,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data
);
  cnt_evt_t          evt;
  logic [CRC_W-1:0]  crc_held;
  logic [EB_W-1:0]   eb_held;
  logic [FAS_W-1:0]  fas_held;

  e1pc_event_qual #(
    .FRAME_BITS(FRAME_W),
    .EB_FRAME_A(EB_FRAME_A),
    .EB_FRAME_B(EB_FRAME_B)
  ) u_qual (
    .clk(clk), .rst(rst),
    .crc_vld(crc_chk_valid), .crc_fail(crc_chk_fail),
    .eb_vld(ebit_valid), .eb_bit(ebit_value), .eb_frame(ebit_frame),
    .fas_err(fas_word_err),
    .fas_lost(lost_fas_sync), .crc_lost(lost_crc_sync), .cas_lost(lost_cas_sync),
    .evt(evt)
  );

  // At most 1000 events per second: the 10-bit tallies never reach a wrap.
  e1pc_interval_cnt #(.W(CRC_W), .SATURATE(1'b0)) u_crc_cnt (
    .clk(clk), .rst(rst), .tick(sec_tick), .inc(evt.crc), .held(crc_held)
  );

  e1pc_interval_cnt #(.W(EB_W), .SATURATE(1'b0)) u_eb_cnt (
    .clk(clk), .rst(rst), .tick(sec_tick), .inc(evt.ebit), .held(eb_held)
  );

  e1pc_interval_cnt #(.W(FAS_W), .SATURATE(1'b1)) u_fas_cnt (
    .clk(clk), .rst(rst), .tick(sec_tick), .inc(evt.fas), .held(fas_held)
  );

  e1pc_reg_map #(.CW(CRC_W), .FW(FAS_W)) u_map (
    .clk(clk), .rst(rst), .addr(rd_addr),
    .crc_cnt(crc_held), .eb_cnt(eb_held), .fas_cnt(fas_held),
    .rdata(rd_data)
  );

  initial begin
    assert (CRC_W == EB_W); // R2
  end
endmodule

// File: tb/e1_perf_counter_bank_test.sv
module e1_perf_counter_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;

  typedef struct packed {
    logic [15:0] n_crc;
    logic [15:0] n_eb_good;
    logic [15:0] n_eb_one;
    logic [15:0] n_eb_wrong;
    logic [15:0] n_fas;
    logic        l_fas;
    logic        l_crc;
    logic        l_cas;
    logic [15:0] e_crc;
    logic [15:0] e_eb;
    logic [15:0] e_fas;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{16'd3,   16'd2,   16'd1, 16'd2, 16'd4,  1'b0, 1'b0, 1'b0, 16'd3,   16'd2,   16'd4},
    '{16'd5,   16'd4,   16'd0, 16'd0, 16'd2,  1'b1, 1'b0, 1'b0, 16'd0,   16'd0,   16'd2},
    '{16'd2,   16'd3,   16'd0, 16'd0, 16'd1,  1'b0, 1'b1, 1'b0, 16'd0,   16'd0,   16'd1},
    '{16'd6,   16'd5,   16'd1, 16'd1, 16'd0,  1'b0, 1'b0, 1'b1, 16'd6,   16'd5,   16'd0},
    '{16'd300, 16'd260, 16'd2, 16'd2, 16'd70, 1'b0, 1'b0, 1'b0, 16'd300, 16'd260, 16'd70}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       crc_chk_valid = 1'b0, crc_chk_fail = 1'b0;
  logic       ebit_valid = 1'b0, ebit_value = 1'b1;
  logic [3:0] ebit_frame = 4'd0;
  logic       fas_word_err = 1'b0;
  logic       lost_fas_sync = 1'b0, lost_crc_sync = 1'b0, lost_cas_sync = 1'b0;
  logic       sec_tick = 1'b0;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_perf_counter_bank uut (
    .clk(clk), .rst(rst),
    .crc_chk_valid(crc_chk_valid), .crc_chk_fail(crc_chk_fail),
    .ebit_valid(ebit_valid), .ebit_value(ebit_value), .ebit_frame(ebit_frame),
    .fas_word_err(fas_word_err),
    .lost_fas_sync(lost_fas_sync), .lost_crc_sync(lost_crc_sync),
    .lost_cas_sync(lost_cas_sync),
    .sec_tick(sec_tick), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  // Expected bytes follow the field placement stated in R1, R2 and R6.
  task automatic check_all(input string req, input int ecrc, input int eeb, input int efas);
    logic [7:0]  d;
    logic [9:0]  c = 10'(ecrc);
    logic [9:0]  e = 10'(eeb);
    logic [11:0] f = 12'(efas);
    rd(8'h02, d); check({req, " R1 R6 @02"}, d, {f[11:6], c[9:8]});
    rd(8'h03, d); check({req, " R1 @03"},    d, c[7:0]);
    rd(8'h04, d); check({req, " R2 R6 @04"}, d, {f[5:0], e[9:8]});
    rd(8'h05, d); check({req, " R2 @05"},    d, e[7:0]);
  endtask

  task automatic ev_crc(input logic fail);
    @(negedge clk); crc_chk_valid = 1'b1; crc_chk_fail = fail;
    @(negedge clk); crc_chk_valid = 1'b0; crc_chk_fail = 1'b0;
  endtask

  task automatic ev_eb(input logic val, input logic [3:0] fr);
    @(negedge clk); ebit_valid = 1'b1; ebit_value = val; ebit_frame = fr;
    @(negedge clk); ebit_valid = 1'b0; ebit_value = 1'b1;
  endtask

  task automatic ev_fas();
    @(negedge clk); fas_word_err = 1'b1;
    @(negedge clk); fas_word_err = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: reset state
    check_all("R10 reset", 0, 0, 0);

    // Vector table: one interval per entry
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      lost_fas_sync = VECS[v].l_fas;
      lost_crc_sync = VECS[v].l_crc;
      lost_cas_sync = VECS[v].l_cas;
      for (int i = 0; i < int'(VECS[v].n_crc); i++) begin
        ev_crc(1'b1);
        if (i == 0) ev_crc(1'b0); // R1: passing check not counted
      end
      for (int i = 0; i < int'(VECS[v].n_eb_good); i++) ev_eb(1'b0, (i % 2 == 0) ? 4'd13 : 4'd15);
      for (int i = 0; i < int'(VECS[v].n_eb_one); i++) ev_eb(1'b1, 4'd13);           // R3
      for (int i = 0; i < int'(VECS[v].n_eb_wrong); i++) ev_eb(1'b0, (i % 2 == 0) ? 4'd14 : 4'd12); // R3
      for (int i = 0; i < int'(VECS[v].n_fas); i++) ev_fas();                          // R6
      tick();
      lost_fas_sync = 1'b0; lost_crc_sync = 1'b0; lost_cas_sync = 1'b0;
      check_all($sformatf("vec%0d R3 R4 R5 R8", v), int'(VECS[v].e_crc),
                int'(VECS[v].e_eb), int'(VECS[v].e_fas));
    end

    // R9: out-of-range addresses read zero while held values are nonzero
    rd(8'h00, d); check("R9 addr 00", d, 8'h00);
    rd(8'h01, d); check("R9 addr 01", d, 8'h00);
    rd(8'h06, d); check("R9 addr 06", d, 8'h00);
    rd(8'hFF, d); check("R9 addr FF", d, 8'h00);

    // R9: repeated reads have no side effect
    rd(8'h03, d); rd(8'h03, d2);
    check("R9 reread", d2, d);
    check("R9 reread value", d, 8'h2C);

    // R9: held value does not follow running events mid-interval
    ev_crc(1'b1); ev_crc(1'b1); ev_eb(1'b0, 4'd15);
    rd(8'h03, d); check("R9 held stable", d, 8'h2C);
    tick();
    check_all("R9 after tick", 2, 1, 0);

    // R8: event coincident with tick counts into the new interval
    ev_crc(1'b1); ev_crc(1'b1);
    @(negedge clk); sec_tick = 1'b1; crc_chk_valid = 1'b1; crc_chk_fail = 1'b1;
    @(negedge clk); sec_tick = 1'b0; crc_chk_valid = 1'b0; crc_chk_fail = 1'b0;
    check_all("R8 tick interval", 2, 0, 0);
    tick();
    check_all("R8 carried event", 1, 0, 0);

    // R7: alignment tally saturates at 4095
    for (int i = 0; i < 4100; i++) ev_fas();
    tick();
    check_all("R7 saturate", 0, 0, 4095);

    // R10: reset clears held and running
    ev_crc(1'b1); ev_fas(); tick();
    ev_crc(1'b1); ev_eb(1'b0, 4'd13);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check_all("R10 held cleared", 0, 0, 0);
    tick();
    check_all("R10 running cleared", 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule